// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general-purpose registers of a 32-bit processor core that runs in one of six operating modes: user/system, fast interrupt, normal interrupt, supervisor, abort and undefined. Each access carries a 4-bit architectural register index and the mode it is made in. The block turns that pair into the physical register the mode owns. Low registers are common to every mode. The stack pointer and link register are private to each exception mode. The fast-interrupt mode also privatises R8 to R12, so its handler can use them without saving the interrupted values.

There are two combinational read ports and one write port, which commits on the rising clock edge. A separate port reaches the saved-status register of each exception mode. The program counter and the current status register are shared state that lives outside this block. Index 15 therefore has no storage here.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous, active-high reset clears every physical register and every saved-status register to zero. Reset takes priority over a write made in the same cycle.
- R2: Indices 0 to 7 name one shared set of registers. A value written in any mode reads back in every mode.
- R3: Both read ports are combinational. A write commits at the rising clock edge. A read of the same register in the cycle of the write returns the old value, and the new value appears in the next cycle.
- R4: For indices 8 to 12, the fast-interrupt mode (code 1) has its own copies. Every other mode reaches the user copies.
- R5: Indices 13 and 14 have a separate copy for the user mode and for each of the five exception modes (codes 1 to 5).
- R6: The mode field is 3 bits: 0 user/system, 1 fast interrupt, 2 normal interrupt, 3 supervisor, 4 abort, 5 undefined. Codes 6 and 7 behave as user.
- R7: Index 15 has no storage in this block. Reads of it return zero on both ports, and writes to it change nothing.
- R8: Each exception mode (codes 1 to 5) has one saved-status register, reached with the port's own mode. In user mode (codes 0, 6, 7) a read returns zero and a write is ignored.
- R9: Each access uses the mode supplied with it. A write to a banked register in one mode leaves the copies of the other modes unchanged.
- R10: The two read ports are independent. In the same cycle they may read different registers in different modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_mode | input | 3 | Mode of read port A |
| rd_a_idx | input | 4 | Register index of read port A |
| rd_a_data | output | DW | Read port A data (combinational) |
| rd_b_mode | input | 3 | Mode of read port B |
| rd_b_idx | input | 4 | Register index of read port B |
| rd_b_data | output | DW | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_mode | input | 3 | Mode of the write |
| wr_idx | input | 4 | Register index of the write |
| wr_data | input | DW | Write data |
| ss_mode | input | 3 | Mode selecting the saved-status register |
| ss_we | input | 1 | Saved-status write enable |
| ss_wdata | input | SW | Saved-status write data |
| ss_rdata | output | SW | Saved-status read data (combinational) |

## Verification
A write and a combinational read of the same physical register can fall in the same cycle. This is provoked by holding a write to R5 in normal-interrupt mode while port A reads that register in that mode. The read must show the old value before the edge and the new value one cycle later. Reset and a write can also coincide. The bench raises reset with a write pending and judges the outcome by reading back zero, in several modes, in the cycles that follow.

// File: rtl/bregs_pkg.sv
package bregs_pkg;

  typedef enum logic [2:0] {
    MD_USR = 3'd0,
    MD_FIQ = 3'd1,
    MD_IRQ = 3'd2,
    MD_SVC = 3'd3,
    MD_ABT = 3'd4,
    MD_UND = 3'd5
  } mode_e;

  localparam int IDX_W      = 4;
  localparam int MODE_W     = 3;
  localparam int SHARED_TOP = 7;    // R0..R7 common to all modes
  localparam int FIQ_LO     = 8;    // first index privatised by fast interrupt
  localparam int SP_IDX     = 13;
  localparam int LR_IDX     = 14;
  localparam int PC_IDX     = 15;   // held outside this block
  localparam int N_EXC      = 5;    // exception modes with banked state

  localparam int N_USER     = PC_IDX;               // user copies R0..R14
  localparam int FIQ_BASE   = N_USER;               // fast-interrupt R8..R14
  localparam int N_FIQ      = LR_IDX - FIQ_LO + 1;
  localparam int OTH_BASE   = FIQ_BASE + N_FIQ;     // R13/R14 of other modes
  localparam int N_OTH      = 2 * (N_EXC - 1);
  localparam int N_PHYS     = OTH_BASE + N_OTH;
  localparam int PHYS_W     = $clog2(N_PHYS);

  function automatic mode_e norm_mode(input logic [MODE_W-1:0] raw);
    case (raw)
      3'd1: norm_mode = MD_FIQ;
      3'd2: norm_mode = MD_IRQ;
      3'd3: norm_mode = MD_SVC;
      3'd4: norm_mode = MD_ABT;
      3'd5: norm_mode = MD_UND;
      default: norm_mode = MD_USR;
    endcase
  endfunction

endpackage

// File: rtl/bregs_map.sv
// Translates (mode, architectural index) into a physical slot number.
module bregs_map
  import bregs_pkg::*;
(
  input  logic [MODE_W-1:0] mode_raw,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys,
  output logic              hit
);

  mode_e md;
  int    slot;
  int    ix;

  always_comb begin
    md   = norm_mode(mode_raw);
    ix   = int'(idx);
    hit  = (ix != PC_IDX);
    slot = ix;
    if (md == MD_FIQ && ix >= FIQ_LO && ix <= LR_IDX) begin
      slot = FIQ_BASE + (ix - FIQ_LO);
    end else if (md != MD_USR && md != MD_FIQ && ix >= SP_IDX && ix <= LR_IDX) begin
      slot = OTH_BASE + 2 * (int'(md) - int'(MD_IRQ)) + (ix - SP_IDX);
    end
    if (!hit) slot = 0;
    phys = PHYS_W'(slot);
  end

endmodule

// File: rtl/bregs_store.sv
// Flat physical storage: one write port, two asynchronous read ports.
module bregs_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 30,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/bregs_saved.sv
// One saved-status register per exception mode; user mode has none.
module bregs_saved
  import bregs_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_raw,
  input  logic              we,
  input  logic [SW-1:0]     wdata,
  output logic [SW-1:0]     rdata
);

  mode_e         md;
  logic [SW-1:0] slot_q [N_EXC];
  logic [N_EXC-1:0] sel;

  assign md = norm_mode(mode_raw);

  for (genvar g = 0; g < N_EXC; g++) begin : g_slot
    assign sel[g] = (md == mode_e'(g + 1));
    always_ff @(posedge clk) begin
      if (rst)               slot_q[g] <= '0;
      else if (we && sel[g]) slot_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < N_EXC; g++) begin
      if (sel[g]) rdata = slot_q[g];
    end
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bregs_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    rd_a_mode,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [2:0]    rd_b_mode,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [2:0]    wr_mode,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    ss_mode,
  input  logic          ss_we,
  input  logic [SW-1:0] ss_wdata,
  output logic [SW-1:0] ss_rdata
);

  logic [PHYS_W-1:0] pa, pb, pw;
  logic              ha, hb, hw;
  logic [DW-1:0]     raw_a, raw_b;

  bregs_map u_map_a (.mode_raw(rd_a_mode), .idx(rd_a_idx), .phys(pa), .hit(ha));
  bregs_map u_map_b (.mode_raw(rd_b_mode), .idx(rd_b_idx), .phys(pb), .hit(hb));
  bregs_map u_map_w (.mode_raw(wr_mode),   .idx(wr_idx),   .phys(pw), .hit(hw));

  bregs_store #(.DW(DW), .DEPTH(N_PHYS)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en && hw),
    .waddr   (pw),
    .wdata   (wr_data),
    .raddr_a (pa),
    .raddr_b (pb),
    .rdata_a (raw_a),
    .rdata_b (raw_b)
  );

  assign rd_a_data = ha ? raw_a : '0;
  assign rd_b_data = hb ? raw_b : '0;

  bregs_saved #(.SW(SW)) u_saved (
    .clk      (clk),
    .rst      (rst),
    .mode_raw (ss_mode),
    .we       (ss_we),
    .wdata    (ss_wdata),
    .rdata    (ss_rdata)
  );

endmodule

// File: rtl/bregs_chk.sv
module bregs_chk #(
  parameter int DW = 32,
  parameter int SW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    rd_a_mode,
  input logic [3:0]    rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic [2:0]    rd_b_mode,
  input logic [3:0]    rd_b_idx,
  input logic [DW-1:0] rd_b_data,
  input logic          wr_en,
  input logic [2:0]    wr_mode,
  input logic [3:0]    wr_idx,
  input logic [DW-1:0] wr_data,
  input logic [2:0]    ss_mode,
  input logic          ss_we,
  input logic [SW-1:0] ss_wdata,
  input logic [SW-1:0] ss_rdata
);

  // R1: the cycle after a reset edge shows zero everywhere
  p_reset_clears_r1: assert property (@(posedge clk)
    $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0 && ss_rdata == '0));

  // R3: a committed write is visible next cycle in the same mode
  p_write_visible_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst) && $past(wr_idx) != 4'd15 &&
     rd_a_mode == $past(wr_mode) && rd_a_idx == $past(wr_idx))
    |-> rd_a_data == $past(wr_data));

  // R2: low registers are shared whatever the read mode
  p_shared_low_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst) && $past(wr_idx) < 4'd8 &&
     rd_b_idx == $past(wr_idx))
    |-> rd_b_data == $past(wr_data));

  // R7: index 15 reads as zero
  p_pc_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rd_a_idx == 4'd15 |-> rd_a_data == '0);

  // R8: no saved status in user mode
  p_user_ss_r8: assert property (@(posedge clk) disable iff (rst)
    (ss_mode == 3'd0 || ss_mode > 3'd5) |-> ss_rdata == '0);

  // R8: saved-status write visible next cycle in the same mode
  p_ss_write_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(ss_we) && !$past(rst) && $past(ss_mode) >= 3'd1 &&
     $past(ss_mode) <= 3'd5 && ss_mode == $past(ss_mode))
    |-> ss_rdata == $past(ss_wdata));

  // R6: codes 6 and 7 alias the user view
  p_alias_user_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_a_mode > 3'd5 && rd_b_mode == 3'd0 && rd_a_idx == rd_b_idx)
    |-> rd_a_data == rd_b_data);

endmodule

bind banked_regfile bregs_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst),
  .rd_a_mode(rd_a_mode), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_mode(rd_b_mode), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_mode(wr_mode), .wr_idx(wr_idx), .wr_data(wr_data),
  .ss_mode(ss_mode), .ss_we(ss_we), .ss_wdata(ss_wdata), .ss_rdata(ss_rdata)
);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;

  localparam int DW = 32;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    rd_a_mode = '0, rd_b_mode = '0, wr_mode = '0, ss_mode = '0;
  logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic          wr_en = 1'b0, ss_we = 1'b0;
  logic [SW-1:0] ss_wdata = '0, ss_rdata;

  always #2 clk = ~clk;   // 250 MHz

  banked_regfile #(.DW(DW), .SW(SW)) dut (
    .clk(clk), .rst(rst),
    .rd_a_mode(rd_a_mode), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_mode(rd_b_mode), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_idx(wr_idx), .wr_data(wr_data),
    .ss_mode(ss_mode), .ss_we(ss_we), .ss_wdata(ss_wdata), .ss_rdata(ss_rdata)
  );

  typedef struct {
    int          port;   // 0 = A, 1 = B, 2 = saved status
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  event  sample_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  // monitor: pops every pending expectation and compares
  always begin
    item_t       it;
    logic [31:0] act;
    @(sample_ev);
    while (sb.size() > 0) begin
      it  = sb.pop_front();
      act = (it.port == 0) ? rd_a_data : (it.port == 1) ? rd_b_data : ss_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int port, input logic [31:0] exp, input string tag);
    item_t it;
    it.port = port; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic fire();
    #1 -> sample_ev;
    #1;
  endtask

  task automatic wr(input logic [2:0] m, input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    wr_mode = m; wr_idx = i; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic ssw(input logic [2:0] m, input logic [31:0] d);
    @(negedge clk);
    ss_mode = m; ss_wdata = d; ss_we = 1'b1;
    @(posedge clk);
    #1 ss_we = 1'b0;
  endtask

  task automatic rda(input logic [2:0] m, input logic [3:0] i, input logic [31:0] e, input string tag);
    @(negedge clk);
    rd_a_mode = m; rd_a_idx = i;
    push(0, e, tag);
    fire();
  endtask

  task automatic rdb(input logic [2:0] m, input logic [3:0] i, input logic [31:0] e, input string tag);
    @(negedge clk);
    rd_b_mode = m; rd_b_idx = i;
    push(1, e, tag);
    fire();
  endtask

  task automatic rds(input logic [2:0] m, input logic [31:0] e, input string tag);
    @(negedge clk);
    ss_mode = m;
    push(2, e, tag);
    fire();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rda(3'd0, 4'd0, 32'h0, "R1 user r0");
    rda(3'd1, 4'd13, 32'h0, "R1 fiq r13");
    rdb(3'd5, 4'd14, 32'h0, "R1 und r14");
    for (int m = 1; m <= 5; m++) rds(3'(m), 32'h0, "R1 saved status");

    // R2 shared low registers
    wr(3'd0, 4'd3, 32'h0000_00A3);
    rda(3'd4, 4'd3, 32'h0000_00A3, "R2 abt sees r3");
    rdb(3'd1, 4'd3, 32'h0000_00A3, "R2 fiq sees r3");

    // R3 same-cycle write and read
    @(negedge clk);
    wr_mode = 3'd2; wr_idx = 4'd5; wr_data = 32'h55; wr_en = 1'b1;
    rd_a_mode = 3'd2; rd_a_idx = 4'd5;
    push(0, 32'h0, "R3 old value in write cycle");
    fire();
    @(posedge clk);
    #1 wr_en = 1'b0;
    rda(3'd2, 4'd5, 32'h55, "R3 new value next cycle");

    // R4 fast-interrupt R8..R12
    wr(3'd0, 4'd10, 32'h0001_000A);
    wr(3'd1, 4'd10, 32'h0000_F00A);
    rda(3'd1, 4'd10, 32'h0000_F00A, "R4 fiq own r10");
    rda(3'd0, 4'd10, 32'h0001_000A, "R4 user r10");
    for (int m = 2; m <= 5; m++) rda(3'(m), 4'd10, 32'h0001_000A, "R4 exc uses user r10");
    wr(3'd3, 4'd12, 32'h3C);
    rda(3'd0, 4'd12, 32'h3C, "R4 svc wrote user r12");
    rdb(3'd1, 4'd12, 32'h0, "R4 fiq r12 untouched");

    // R5 per-mode R13
    for (int m = 0; m <= 5; m++) wr(3'(m), 4'd13, 32'hD00 + m);
    for (int m = 0; m <= 5; m++) rda(3'(m), 4'd13, 32'hD00 + m, "R5 banked r13");

    // R6 codes 6 and 7 as user
    wr(3'd7, 4'd13, 32'h77);
    rda(3'd0, 4'd13, 32'h77, "R6 code 7 wrote user r13");
    rdb(3'd6, 4'd13, 32'h77, "R6 code 6 reads user r13");
    rda(3'd1, 4'd13, 32'hD01, "R6 fiq r13 kept");

    // R7 index 15
    wr(3'd2, 4'd15, 32'hDEAD_BEEF);
    rda(3'd2, 4'd15, 32'h0, "R7 port A r15");
    rdb(3'd0, 4'd15, 32'h0, "R7 port B r15");
    rda(3'd2, 4'd14, 32'h0, "R7 no stray write");

    // R8 saved status
    for (int m = 1; m <= 5; m++) ssw(3'(m), 32'h500 + m);
    for (int m = 1; m <= 5; m++) rds(3'(m), 32'h500 + m, "R8 saved status per mode");
    ssw(3'd0, 32'hFFFF);
    rds(3'd0, 32'h0, "R8 user read zero");
    rds(3'd6, 32'h0, "R8 code 6 read zero");
    rds(3'd3, 32'h503, "R8 user write ignored");

    // R9 isolation by access mode
    wr(3'd4, 4'd14, 32'hABC);
    rda(3'd4, 4'd14, 32'hABC, "R9 abt r14");
    rda(3'd0, 4'd14, 32'h0, "R9 user r14 untouched");
    rda(3'd3, 4'd14, 32'h0, "R9 svc r14 untouched");
    rdb(3'd1, 4'd14, 32'h0, "R9 fiq r14 untouched");

    // R10 independent ports in one cycle
    @(negedge clk);
    rd_a_mode = 3'd1; rd_a_idx = 4'd10;
    rd_b_mode = 3'd2; rd_b_idx = 4'd10;
    push(0, 32'h0000_F00A, "R10 port A fiq r10");
    push(1, 32'h0001_000A, "R10 port B irq r10");
    fire();

    // R1 reset beats a pending write
    @(negedge clk);
    rst = 1'b1; wr_mode = 3'd0; wr_idx = 4'd3; wr_data = 32'h99; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0; rst = 1'b0;
    rda(3'd0, 4'd3, 32'h0, "R1 reset wins over write");
    rda(3'd1, 4'd10, 32'h0, "R1 fiq r10 cleared");
    rds(3'd3, 32'h0, "R1 saved status cleared");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule